// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling enable for a serial transmitter and receiver from the peripheral clock. The divisor is a fixed-point number with an integer part of `INT_W` bits and a fraction of `FRAC_W` bits, counted in sixty-fourths of a clock with the default width. The generator emits one `baud16_tick` per divisor period, which gives 16 ticks per serial bit. It also emits a `bit_tick` on every sixteenth of those ticks.

Software writes the integer and fractional divisor through two write strobes. Those writes only fill a pending copy. The running divisor takes the pending values when the line-control write strobe `lcr_wr` pulses, even if that write changes no bits. The fraction is spread over time by an accumulator of `FRAC_W` bits. Each divisor period adds the fraction to the accumulator, and a carry out of it lengthens that period by one clock. The average period is therefore `IBRD + FBRD/64` clocks, and the bit rate is `4*clk / (64*IBRD + FBRD)`.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset the pending and running divisors are both zero, and neither `baud16_tick` nor `bit_tick` pulses.
- R2: With a zero fraction and `en` high, `baud16_tick` pulses once every IBRD clocks. IBRD = 1 gives a pulse on every clock.
- R3: A write on `ibrd_wr` or `fbrd_wr` changes only the pending divisor. The running divisor takes the pending values on the clock after an `lcr_wr` pulse, and holds them on every other clock.
- R4: With fraction F, period k (counting from 1 after enable) lasts IBRD + floor(k*F/64) - floor((k-1)*F/64) clocks. Each carry out of the 6-bit accumulator adds one clock to that period.
- R5: The integer divisor reaches 65535. With IBRD = 65535 and F = 63, the second period lasts 65536 clocks.
- R6: `bit_tick` pulses in the same cycle as every sixteenth `baud16_tick` and at no other time. Its count restarts whenever the generator is stopped, so the first `bit_tick` after a restart falls on the sixteenth tick.
- R7: A running integer divisor of zero stops the generator, and no ticks are produced.
- R8: While `en` is low, no ticks appear and the counters and the accumulator are held cleared. An `lcr_wr` pulse still loads the running divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Serial block enable; low holds the counters cleared |
| ibrd_wr | input | 1 | Write strobe for the pending integer divisor |
| ibrd_wdata | input | INT_W | Integer divisor write data |
| fbrd_wr | input | 1 | Write strobe for the pending fractional divisor |
| fbrd_wdata | input | FRAC_W | Fractional divisor write data, in 1/2^FRAC_W clocks |
| lcr_wr | input | 1 | Line-control write strobe; copies pending into running divisor |
| baud16_tick | output | 1 | One-clock pulse per divisor period (16 per bit) |
| bit_tick | output | 1 | One-clock pulse on every sixteenth baud16_tick |

## Verification
The bench builds the block with its default parameters: a 16-bit integer part, a 6-bit fraction and 16 ticks per bit. With these values the full-scale divisor of 65535 can be run inside the cycle budget, so the carry-lengthened period of 65536 clocks is observed directly. The 6-bit fraction makes the carry pattern of fractions such as 21, 32 and 63 visible within a few dozen periods. The 16-tick bit divider is checked across runs long enough to cross several bit boundaries, including a run that is stopped partway through a bit.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 6;
  localparam int unsigned DEF_OVS    = 16;

  // carry out of a FRAC_W-bit accumulator when the fraction is added
  function automatic logic frac_carry(input int unsigned acc,
                                      input int unsigned frac,
                                      input int unsigned width);
    return ((acc + frac) >> width) != 0;
  endfunction

  // last count of a divisor period, counted from zero
  function automatic int unsigned period_last(input int unsigned ibrd,
                                              input logic carry);
    return ibrd - 1 + (carry ? 1 : 0);
  endfunction
endpackage

// File: rtl/divisor_regs.sv
module divisor_regs #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ibrd_wr,
  input  logic [INT_W-1:0]  ibrd_wdata,
  input  logic              fbrd_wr,
  input  logic [FRAC_W-1:0] fbrd_wdata,
  input  logic              lcr_wr,
  output logic [INT_W-1:0]  act_ibrd,
  output logic [FRAC_W-1:0] act_fbrd
);
  logic [INT_W-1:0]  pend_ibrd;
  logic [FRAC_W-1:0] pend_fbrd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ibrd <= '0;
      pend_fbrd <= '0;
    end else begin
      if (ibrd_wr) pend_ibrd <= ibrd_wdata;
      if (fbrd_wr) pend_fbrd <= fbrd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ibrd <= '0;
      act_fbrd <= '0;
    end else if (lcr_wr) begin
      act_ibrd <= pend_ibrd;
      act_fbrd <= pend_fbrd;
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> ($stable(act_ibrd) && $stable(act_fbrd))); // R3
  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr |=> (act_ibrd == $past(pend_ibrd) && act_fbrd == $past(pend_fbrd))); // R3
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  ibrd,
  input  logic [FRAC_W-1:0] fbrd,
  output logic              tick_o
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_cnt;
  logic [FRAC_W-1:0] acc;
  logic              carry;
  logic              wrap;
  logic              tick_q;

  always_comb begin
    carry    = baud_pkg::frac_carry(32'(acc), 32'(fbrd), FRAC_W);
    last_cnt = CNT_W'(baud_pkg::period_last(32'(ibrd), carry));
    wrap     = run && (cnt >= last_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      acc    <= '0;
      tick_q <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      acc    <= acc + fbrd;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q & run;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && acc == '0)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(ibrd)) |-> (cnt <= CNT_W'(ibrd))); // R4
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ibrd == '0) |-> !tick_o); // R7
endmodule

// File: rtl/bit_divider.sv
module bit_divider #(
  parameter int unsigned OVS = baud_pkg::DEF_OVS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_o
);
  localparam int unsigned BW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BW-1:0] LAST = BW'(OVS - 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign bit_o = tick && (cnt == LAST);

  AST_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R6
  AST_BIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |=> (cnt == '0)); // R6
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W,
  parameter int unsigned OVS    = baud_pkg::DEF_OVS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ibrd_wr,
  input  logic [INT_W-1:0]  ibrd_wdata,
  input  logic              fbrd_wr,
  input  logic [FRAC_W-1:0] fbrd_wdata,
  input  logic              lcr_wr,
  output logic              baud16_tick,
  output logic              bit_tick
);
  logic [INT_W-1:0]  act_ibrd;
  logic [FRAC_W-1:0] act_fbrd;
  logic              run;

  divisor_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ibrd_wr(ibrd_wr), .ibrd_wdata(ibrd_wdata),
    .fbrd_wr(fbrd_wr), .fbrd_wdata(fbrd_wdata),
    .lcr_wr(lcr_wr),
    .act_ibrd(act_ibrd), .act_fbrd(act_fbrd)
  );

  assign run = en && (act_ibrd != '0);

  frac_tick_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ibrd(act_ibrd), .fbrd(act_fbrd),
    .tick_o(baud16_tick)
  );

  bit_divider #(.OVS(OVS)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(run),
    .tick(baud16_tick), .bit_o(bit_tick)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!baud16_tick && !bit_tick)); // R8
  AST_BIT_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> baud16_tick); // R6
endmodule

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ibrd_wr = 1'b0;
  logic [15:0] ibrd_wdata = '0;
  logic        fbrd_wr = 1'b0;
  logic [5:0]  fbrd_wdata = '0;
  logic        lcr_wr = 1'b0;
  logic        baud16_tick, bit_tick;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string cur_req = "R2";
  int cyc = 0;
  int n16 = 0;
  bit first = 1'b1;
  int total_cycles = 0;

  baud_frac_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ibrd_wr(ibrd_wr), .ibrd_wdata(ibrd_wdata),
    .fbrd_wr(fbrd_wr), .fbrd_wdata(fbrd_wdata),
    .lcr_wr(lcr_wr),
    .baud16_tick(baud16_tick), .bit_tick(bit_tick)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int i, input int f, input int k);
    return i + (k * f) / 64 - ((k - 1) * f) / 64;
  endfunction

  // monitor: scoreboard on period lengths and bit pulses
  always @(negedge clk) begin
    total_cycles++;
    if (!en) begin
      first = 1'b1;
      cyc = 0;
      n16 = 0;
    end else begin
      cyc++;
      if (bit_tick && !baud16_tick)
        check(1'b0, "R6 bit_tick without baud16_tick", 1, 0);
      if (baud16_tick) begin
        n16++;
        check(bit_tick == ((n16 % 16) == 0), "R6 bit_tick position",
              int'(bit_tick), int'((n16 % 16) == 0));
        if (first) begin
          first = 1'b0;
        end else if (exp_q.size() != 0) begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, cur_req, cyc, e);
        end
        cyc = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_ibrd(input int v);
    step(); ibrd_wr = 1'b1; ibrd_wdata = 16'(v);
    step(); ibrd_wr = 1'b0;
  endtask

  task automatic wr_fbrd(input int v);
    step(); fbrd_wr = 1'b1; fbrd_wdata = 6'(v);
    step(); fbrd_wr = 1'b0;
  endtask

  task automatic wr_lcr();
    step(); lcr_wr = 1'b1;
    step(); lcr_wr = 1'b0;
  endtask

  // driver: push expected periods 2..n+1, then run until consumed
  task automatic run_case(input int i, input int f, input int n, input int limit,
                          input string req);
    int w;
    cur_req = req;
    for (int k = 2; k <= n + 1; k++) exp_q.push_back(period_of(i, f, k));
    step(); en = 1'b1;
    w = 0;
    while (exp_q.size() != 0 && w < limit) begin
      step(); w++;
    end
    check(exp_q.size() == 0, {req, " periods observed"}, exp_q.size(), 0);
    exp_q.delete();
    step(); en = 1'b0;
    repeat (3) step();
  endtask

  task automatic quiet_check(input int n, input string req);
    int seen;
    seen = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (baud16_tick || bit_tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(baud16_tick == 1'b0, "R1 reset baud16_tick", int'(baud16_tick), 0);
    rst_n = 1'b1;
    step();
    en = 1'b1;
    quiet_check(40, "R1 no ticks with zero divisor after reset");
    step(); en = 1'b0;

    // R2: integer-only divisors
    wr_ibrd(1); wr_fbrd(0); wr_lcr();
    run_case(1, 0, 40, 200, "R2 ibrd=1 every clock");
    wr_ibrd(5); wr_lcr();
    run_case(5, 0, 20, 400, "R2 ibrd=5");

    // R6: stop mid-bit, restart must count 16 fresh ticks
    wr_ibrd(1); wr_lcr();
    run_case(1, 0, 20, 200, "R6 partial bit run");
    run_case(1, 0, 40, 200, "R6 restart run");

    // R4: fractional spreading
    wr_ibrd(3); wr_fbrd(32); wr_lcr();
    run_case(3, 32, 12, 400, "R4 ibrd=3 f=32");
    wr_ibrd(2); wr_fbrd(21); wr_lcr();
    run_case(2, 21, 70, 1000, "R4 ibrd=2 f=21");
    wr_ibrd(7); wr_fbrd(63); wr_lcr();
    run_case(7, 63, 20, 1000, "R4 ibrd=7 f=63");

    // R3: pending writes have no effect until the line-control strobe
    wr_ibrd(4); wr_fbrd(0); wr_lcr();
    wr_ibrd(9); wr_fbrd(32);
    run_case(4, 0, 10, 400, "R3 pending write ignored");
    wr_lcr();
    run_case(9, 32, 10, 400, "R3 latched by lcr_wr");

    // R8: enable low gives no ticks; lcr_wr still loads while disabled
    wr_ibrd(2); wr_fbrd(0); wr_lcr();
    quiet_check(60, "R8 no ticks while en low");
    wr_ibrd(6);
    wr_lcr();
    run_case(6, 0, 10, 400, "R8 load while disabled");

    // R7: zero integer divisor stops generator
    wr_ibrd(0); wr_fbrd(17); wr_lcr();
    step(); en = 1'b1;
    quiet_check(100, "R7 ibrd=0 no ticks");
    step(); en = 1'b0;

    // R5: full-scale divisor
    wr_ibrd(65535); wr_fbrd(63); wr_lcr();
    run_case(65535, 63, 1, 140000, "R5 ibrd=65535 f=63");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    wait (total_cycles >= 195000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", total_cycles, 195000);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule